// File: doc/BRIEF.md
# Rotating Barrel Shifter with Window Extraction

This unit moves the bits of a WIDTH-bit word by any amount from 0 to WIDTH-1 places. It can rotate right or left (bits leaving one end come back in at the other), shift right or left logically (vacated places are filled with zeros), or pull out a group of WIDTH/2 neighbouring bits from the word. All of these operations run through a single right-rotate crossbar. Each amount has its own select line, and at most one select line is active at a time. A left rotate by k uses the right-rotate line for (WIDTH-k) mod WIDTH. A logical shift is a rotate followed by a mask that clears the bit positions that wrapped around.

The amount comes from one of two places. It can be a binary number, which the unit decodes to one-hot. Or, with `in_hot_sel` high, it can be a one-hot vector supplied by the caller. Any control that makes no sense raises `out_bad` and forces the result to zero. That covers a bad one-hot vector, an unused operation code, and a window that would run past the top of the word.

Requests come in on a valid/ready stream, and results leave on another valid/ready stream through a single output register. Back-pressure works as follows. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged.

Top module: `bsh_rotate_unit`

## Requirements
- R1: While reset is asserted and after its release, out_valid, out_data and out_bad are 0, and in_ready is 1.
- R2: Operation code 0 (rotate right by k) gives out_data[i] = in_data[(i+k) mod WIDTH].
- R3: Operation code 1 (rotate left by k) gives the same word as rotate right by (WIDTH-k) mod WIDTH. For example, with WIDTH=8, 8'hB4 rotated left by 1 gives 8'h69.
- R4: Operation code 2 (logical shift right by k) gives in_data >> k, so the top k bits are zero.
- R5: Operation code 3 (logical shift left by k) gives in_data << k, so the low k bits are zero.
- R6: Operation code 4 (window) with k < WIDTH/2 places in_data[k+WIDTH/2-1:k] in the low half of out_data and zeros in the high half. With k >= WIDTH/2 it sets out_bad and gives zero data.
- R7: With in_hot_sel=1, the amount is the index of the single set bit of in_hot. If in_hot does not have exactly one bit set, out_bad is 1 and out_data is 0. With in_hot_sel=0, in_hot has no effect.
- R8: Operation codes 5 to 7 set out_bad and give zero data.
- R9: A result is presented with out_valid on the cycle after it is accepted. While out_valid=1 and out_ready=0, in_ready is 0 and out_data and out_bad hold. When the output drains and a new request arrives on the same edge, both transfers happen on that edge.
- R10: An amount of 0 passes in_data unchanged for operation codes 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_data | input | WIDTH | Word to move |
| in_op | input | 3 | Operation: 0 ror, 1 rol, 2 shr, 3 shl, 4 window |
| in_amt | input | AMT_W | Binary amount |
| in_hot | input | WIDTH | One-hot amount |
| in_hot_sel | input | 1 | 1 selects in_hot as the amount |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | WIDTH | Result word |
| out_bad | output | 1 | Illegal control seen; data is zero |

## Verification
Some properties are checked on every cycle. A held result stays stable under back-pressure, and an accepted request always produces a valid result on the next cycle. A raised illegal flag always comes with zero data. Unused operation codes, malformed one-hot amounts and out-of-range windows always raise the flag. A zero amount always passes the data through.

Other behaviour can only be shown by the bench's scenarios. This covers the exact bit placement for each operation and amount, which is compared against an independent shift-operator model over every amount and operation. It also covers the equivalence between left rotation and right rotation, and the handover where the output drains and a new request is taken on the same edge.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  localparam int OP_W = 3;
  typedef enum logic [OP_W-1:0] {
    OP_ROR = 3'd0,
    OP_ROL = 3'd1,
    OP_SHR = 3'd2,
    OP_SHL = 3'd3,
    OP_WIN = 3'd4
  } bsh_op_e;
endpackage

// File: rtl/bsh_amt_select.sv
// Chooses the amount source and produces one-hot select lines plus legality.
module bsh_amt_select #(
  parameter int WIDTH = 8,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic [AMT_W-1:0] amt_bin,
  input  logic [WIDTH-1:0] amt_hot,
  input  logic             hot_sel,
  output logic [WIDTH-1:0] sel,
  output logic             hot_bad,
  output logic             win_ok
);
  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] bin_hot;
  logic [HALF-1:0]  low_hit;

  for (genvar k = 0; k < WIDTH; k++) begin : g_dec
    assign bin_hot[k] = (amt_bin == AMT_W'(k));
  end

  assign sel = hot_sel ? amt_hot : bin_hot;

  // Exactly one bit set: nonzero and clearing the lowest set bit leaves zero.
  assign hot_bad = hot_sel &&
                   ((amt_hot == '0) || ((amt_hot & (amt_hot - 1'b1)) != '0));

  for (genvar k = 0; k < HALF; k++) begin : g_low
    assign low_hit[k] = sel[k];
  end
  assign win_ok = |low_hit;
endmodule

// File: rtl/bsh_line_map.sv
// Maps a left amount k onto right-rotate line (WIDTH-k) mod WIDTH.
module bsh_line_map #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] sel,
  input  logic             go_left,
  output logic [WIDTH-1:0] lines
);
  logic [WIDTH-1:0] left_lines;

  for (genvar j = 0; j < WIDTH; j++) begin : g_map
    assign left_lines[j] = sel[(WIDTH - j) % WIDTH];
  end

  assign lines = go_left ? left_lines : sel;
endmodule

// File: rtl/bsh_ror_xbar.sv
// Right-rotate crossbar: output i connects to input (i+k) mod WIDTH on line k.
module bsh_ror_xbar #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] data,
  input  logic [WIDTH-1:0] lines,
  output logic [WIDTH-1:0] rot
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_out
    logic [WIDTH-1:0] tap;
    for (genvar k = 0; k < WIDTH; k++) begin : g_tap
      assign tap[k] = data[(i + k) % WIDTH];
    end
    assign rot[i] = |(tap & lines);
  end
endmodule

// File: rtl/bsh_keep_mask.sv
// Per-bit keep mask that clears wrapped positions for shifts and the high half for windows.
module bsh_keep_mask #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]        sel,
  input  bsh_pkg::bsh_op_e        op,
  output logic [WIDTH-1:0]        keep
);
  import bsh_pkg::*;
  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] keep_shr;
  logic [WIDTH-1:0] keep_shl;
  logic [WIDTH-1:0] keep_win;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [WIDTH-1:0] shr_ok;
    logic [WIDTH-1:0] shl_ok;
    for (genvar k = 0; k < WIDTH; k++) begin : g_amt
      assign shr_ok[k] = (i + k < WIDTH) ? sel[k] : 1'b0;
      assign shl_ok[k] = (i >= k)        ? sel[k] : 1'b0;
    end
    assign keep_shr[i] = |shr_ok;
    assign keep_shl[i] = |shl_ok;
    assign keep_win[i] = (i < HALF);
  end

  always_comb begin
    unique case (op)
      OP_SHR:  keep = keep_shr;
      OP_SHL:  keep = keep_shl;
      OP_WIN:  keep = keep_win;
      default: keep = '1;
    endcase
  end
endmodule

// File: rtl/bsh_rotate_unit.sv
module bsh_rotate_unit #(
  parameter int WIDTH = 8,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [WIDTH-1:0]        in_data,
  input  logic [bsh_pkg::OP_W-1:0] in_op,
  input  logic [AMT_W-1:0]        in_amt,
  input  logic [WIDTH-1:0]        in_hot,
  input  logic                    in_hot_sel,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [WIDTH-1:0]        out_data,
  output logic                    out_bad
);
  import bsh_pkg::*;

  logic [WIDTH-1:0] sel;
  logic [WIDTH-1:0] lines;
  logic [WIDTH-1:0] rot;
  logic [WIDTH-1:0] keep;
  logic             hot_bad;
  logic             win_ok;
  logic             op_bad;
  logic             any_bad;
  bsh_op_e          op;
  logic [WIDTH-1:0] nxt_data;
  logic             take;

  assign op_bad = (in_op > OP_W'(OP_WIN));
  assign op     = op_bad ? OP_ROR : bsh_op_e'(in_op);

  bsh_amt_select #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_amt (
    .amt_bin (in_amt),
    .amt_hot (in_hot),
    .hot_sel (in_hot_sel),
    .sel     (sel),
    .hot_bad (hot_bad),
    .win_ok  (win_ok)
  );

  bsh_line_map #(.WIDTH(WIDTH)) u_map (
    .sel     (sel),
    .go_left ((op == OP_ROL) || (op == OP_SHL)),
    .lines   (lines)
  );

  bsh_ror_xbar #(.WIDTH(WIDTH)) u_xbar (
    .data  (in_data),
    .lines (lines),
    .rot   (rot)
  );

  bsh_keep_mask #(.WIDTH(WIDTH)) u_mask (
    .sel  (sel),
    .op   (op),
    .keep (keep)
  );

  assign any_bad  = op_bad || hot_bad || ((op == OP_WIN) && !win_ok);
  assign nxt_data = any_bad ? '0 : (rot & keep);

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_bad   <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= nxt_data;
      out_bad   <= any_bad;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bsh_rotate_checker.sv
module bsh_rotate_checker #(
  parameter int WIDTH = 8,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] in_data,
  input logic [2:0]       in_op,
  input logic [AMT_W-1:0] in_amt,
  input logic [WIDTH-1:0] in_hot,
  input logic             in_hot_sel,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_data,
  input logic             out_bad
);
  logic acc;
  assign acc = in_valid && in_ready;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_bad));

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_bad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_bad |-> out_data == '0);

  p_badop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op > 3'd4) |=> out_bad);

  p_badhot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_hot_sel && ($countones(in_hot) != 1) |=> out_bad && out_data == '0);

  p_winrange_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_hot_sel && (in_op == 3'd4) && (int'(in_amt) >= WIDTH / 2) |=> out_bad);

  p_zero_amt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_hot_sel && (in_amt == '0) && (in_op < 3'd4) |=> out_data == $past(in_data));
endmodule

bind bsh_rotate_unit bsh_rotate_checker #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_op(in_op), .in_amt(in_amt), .in_hot(in_hot),
  .in_hot_sel(in_hot_sel), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_bad(out_bad)
);

// File: tb/bsh_rotate_unit_bench.sv
`timescale 1ns/1ps
module bsh_rotate_unit_bench;
  localparam int N = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_hot_sel = 1'b0;
  logic [N-1:0] in_data = '0, in_hot = '0;
  logic [2:0] in_op = '0;
  logic [AW-1:0] in_amt = '0;
  logic out_valid, out_ready = 1'b1, out_bad;
  logic [N-1:0] out_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bsh_rotate_unit #(.WIDTH(N), .AMT_W(AW)) u_bsh_rotate_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_op(in_op), .in_amt(in_amt), .in_hot(in_hot),
    .in_hot_sel(in_hot_sel), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_bad(out_bad)
  );

  // {op, amt, data, expected data, expected bad}
  localparam logic [22:0] VEC [14] = '{
    {3'd0, 3'd1, 8'hB4, 8'h5A, 1'b0},  // R2
    {3'd0, 3'd3, 8'hB4, 8'h96, 1'b0},  // R2
    {3'd1, 3'd1, 8'hB4, 8'h69, 1'b0},  // R3
    {3'd1, 3'd4, 8'hB4, 8'h4B, 1'b0},  // R3
    {3'd2, 3'd2, 8'hB4, 8'h2D, 1'b0},  // R4
    {3'd3, 3'd3, 8'hB4, 8'hA0, 1'b0},  // R5
    {3'd4, 3'd2, 8'hB4, 8'h0D, 1'b0},  // R6
    {3'd4, 3'd0, 8'hB4, 8'h04, 1'b0},  // R6
    {3'd4, 3'd3, 8'hB4, 8'h06, 1'b0},  // R6
    {3'd0, 3'd0, 8'h3C, 8'h3C, 1'b0},  // R10
    {3'd3, 3'd7, 8'h81, 8'h80, 1'b0},  // R5
    {3'd2, 3'd7, 8'h81, 8'h01, 1'b0},  // R4
    {3'd4, 3'd4, 8'hFF, 8'h00, 1'b1},  // R6
    {3'd5, 3'd1, 8'hFF, 8'h00, 1'b1}   // R8
  };

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R8";
    endcase
  endfunction

  // Behavioural model built on shift operators.
  function automatic logic [N:0] model(input logic [2:0] op, input int k, input logic [N-1:0] d);
    logic [N-1:0] r;
    logic bad;
    bad = 1'b0;
    case (op)
      3'd0: r = (d >> k) | (d << (N - k));
      3'd1: r = (d << k) | (d >> (N - k));
      3'd2: r = d >> k;
      3'd3: r = d << k;
      3'd4: begin r = (d >> k) & 8'h0F; bad = (k >= N / 2); end
      default: begin r = '0; bad = 1'b1; end
    endcase
    if (bad) r = '0;
    return {r, bad};
  endfunction

  task automatic check(input string req, input logic [N-1:0] got_d, input logic got_b,
                       input logic [N-1:0] exp_d, input logic exp_b);
    checks++;
    if (got_d !== exp_d || got_b !== exp_b) begin
      errors++;
      $display("FAIL %s: data %h bad %b, expected data %h bad %b", req, got_d, got_b, exp_d, exp_b);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [AW-1:0] amt, input logic [N-1:0] d,
                      input logic hsel, input logic [N-1:0] hot);
    @(negedge clk);
    in_op = op; in_amt = amt; in_data = d; in_hot_sel = hsel; in_hot = hot;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b1) begin
      errors++;
      $display("FAIL R9: out_valid %b, expected 1 after acceptance", out_valid);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", out_data, out_bad, '0, 1'b0);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1: out_valid %b in_ready %b, expected 0 1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", out_data, out_bad, '0, 1'b0);

    // Vector table; in_hot holds garbage to show it is ignored (R7)
    foreach (VEC[i]) begin
      send(VEC[i][22:20], VEC[i][19:17], VEC[i][16:9], 1'b0, 8'hFF);
      check(req_of(VEC[i][22:20]), out_data, out_bad, VEC[i][8:1], VEC[i][0]);
    end

    // Every operation code and amount against the model
    for (int op = 0; op < 8; op++) begin
      for (int k = 0; k < N; k++) begin
        logic [N:0] e;
        e = model(3'(op), k, 8'hC5 ^ 8'(k * 37));
        send(3'(op), AW'(k), 8'hC5 ^ 8'(k * 37), 1'b0, 8'h5A);
        check(req_of(3'(op)), out_data, out_bad, e[N:1], e[0]);
      end
    end

    // R7: one-hot amount source
    for (int k = 0; k < N; k++) begin
      logic [N:0] e;
      e = model(3'd0, k, 8'hB4);
      send(3'd0, AW'(7 - k), 8'hB4, 1'b1, 8'(1 << k));
      check("R7", out_data, out_bad, e[N:1], e[0]);
    end
    send(3'd0, 3'd1, 8'hB4, 1'b1, 8'h00);
    check("R7", out_data, out_bad, 8'h00, 1'b1);
    send(3'd1, 3'd1, 8'hB4, 1'b1, 8'h11);
    check("R7", out_data, out_bad, 8'h00, 1'b1);
    send(3'd2, 3'd1, 8'hFF, 1'b1, 8'hFF);
    check("R7", out_data, out_bad, 8'h00, 1'b1);

    // R9: back-pressure, hold and same-edge handover
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 3'd0; in_amt = 3'd1; in_data = 8'hB4; in_hot_sel = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_data = 8'h3C; in_op = 3'd3; in_amt = 3'd2;
    check("R9", out_data, out_bad, 8'h5A, 1'b0);
    checks++;
    if (out_valid !== 1'b1 || in_ready !== 1'b0) begin
      errors++;
      $display("FAIL R9: out_valid %b in_ready %b, expected 1 0", out_valid, in_ready);
    end
    repeat (3) @(negedge clk);
    check("R9", out_data, out_bad, 8'h5A, 1'b0);
    checks++;
    if (in_ready !== 1'b0) begin
      errors++;
      $display("FAIL R9: in_ready %b, expected 0 while stalled", in_ready);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b1) begin
      errors++;
      $display("FAIL R9: out_valid %b, expected 1 after handover", out_valid);
    end
    check("R9", out_data, out_bad, 8'hF0, 1'b0);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9: out_valid %b, expected 0 after drain", out_valid);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule